// File: doc/BRIEF.md
# Nearest-Neighbour Source Address Generator

This block sits at the tail of a perspective-warp datapath. For every output pixel it receives two signed fixed-point mapping coefficients, each with 9 fractional bits. It combines them with a static anchor vertex and two static edge vectors, which an earlier coefficient stage has already computed and holds in registers. The result is the real-valued location of the matching source pixel on both axes. It rounds each coordinate to the nearest integer pixel and emits the raster address of that pixel in a 640 x 480 source frame.

The pipeline is fixed and four registers deep, and it never stalls, so a pixel can enter on every clock. A coordinate that lands off the source frame raises a flag so that the consumer can substitute black. In that case the address is forced to zero. The memory read that follows is not part of this block.

Top module: `nn_src_addr_gen`

## Requirements
- R1: The row-axis value is qr = y0*er0 + y1*er1 + vr and the column-axis value is qc = y0*ec0 + y1*ec1 + vc. y0 and y1 are signed with 9 fractional bits. The edge terms (er0, er1, ec0, ec1) and the anchor terms (vr, vc) are signed integers. Both axes are computed in parallel.
- R2: Each axis rounds half up: the integer result is floor(q + 0.5). A fraction of exactly 0.5 rounds to the next integer, and a fraction just below 0.5 rounds down.
- R3: For an in-range pixel, addr_o = row_o*640 + col_o. row_o is the rounded row-axis value and col_o is the rounded column-axis value.
- R4: valid_o rises exactly four clock edges after the edge that samples valid_i high. valid_o is never high at any other time.
- R5: Pixels presented on consecutive cycles are all accepted. They leave on consecutive cycles in the same order.
- R6: oor_o is 1 when row_o lies outside 0..479 or col_o lies outside 0..639. When oor_o is 1, addr_o is 0, and row_o and col_o still show the rounded values.
- R7: Negative coefficients, edges and anchors use two's complement arithmetic. A result of exactly -0.5 rounds to 0, and a result just below -0.5 rounds to -1.
- R8: While rst_ni is low, valid_o, oor_o, addr_o, row_o and col_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Coefficient pair present this cycle |
| y0_i | input | 18 | Signed coefficient along the first edge, 9 fractional bits |
| y1_i | input | 18 | Signed coefficient along the second edge, 9 fractional bits |
| vr_i | input | 12 | Signed anchor vertex, row axis |
| vc_i | input | 12 | Signed anchor vertex, column axis |
| er0_i | input | 12 | Signed first-edge difference, row axis |
| er1_i | input | 12 | Signed second-edge difference, row axis |
| ec0_i | input | 12 | Signed first-edge difference, column axis |
| ec1_i | input | 12 | Signed second-edge difference, column axis |
| valid_o | output | 1 | Result present this cycle |
| row_o | output | 23 | Signed rounded row coordinate |
| col_o | output | 23 | Signed rounded column coordinate |
| oor_o | output | 1 | Coordinate outside the source frame |
| addr_o | output | 19 | Raster address of the nearest source pixel |

## Verification
Rounding and the range check can decide the same pixel in the same cycle. A coordinate of 479.5 or 639.5 sits inside the frame before rounding and outside it after. A coordinate of -0.5 rounds back into the frame, while -0.502 does not. The bench drives these exact fractions through unit edge vectors with the anchor placed on the frame border. It then checks that oor_o and addr_o follow the rounded value and not the truncated one. Each result is also matched against the cycle on which it is due, including a burst of back-to-back pixels.

// File: rtl/nnag_pkg.sv
`timescale 1ns/1ps
package nnag_pkg;
  localparam int NUM_AX = 2;

  typedef enum int {
    AX_ROW = 0,
    AX_COL = 1
  } axis_e;

  function automatic int axis_limit(axis_e ax, int h, int w);
    return (ax == AX_ROW) ? h : w;
  endfunction
endpackage

// File: rtl/nnag_axis_mac.sv
`timescale 1ns/1ps
// Two stages: products, then sum with the anchor shifted into fixed point.
module nnag_axis_mac #(
  parameter int COEF_W = 18,
  parameter int EDGE_W = 12,
  parameter int VTX_W  = 12,
  parameter int FRAC_W = 9,
  localparam int PROD_W = COEF_W + EDGE_W,
  localparam int SUM_W  = PROD_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [COEF_W-1:0] y0_i,
  input  logic signed [COEF_W-1:0] y1_i,
  input  logic signed [EDGE_W-1:0] e0_i,
  input  logic signed [EDGE_W-1:0] e1_i,
  input  logic signed [VTX_W-1:0]  vtx_i,
  output logic signed [SUM_W-1:0]  q_o
);
  logic signed [PROD_W-1:0] p0_q, p1_q;
  logic signed [VTX_W-1:0]  vtx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_q  <= '0;
      p1_q  <= '0;
      vtx_q <= '0;
    end else begin
      p0_q  <= PROD_W'(y0_i) * PROD_W'(e0_i);
      p1_q  <= PROD_W'(y1_i) * PROD_W'(e1_i);
      vtx_q <= vtx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= SUM_W'(p0_q) + SUM_W'(p1_q) + (SUM_W'(vtx_q) <<< FRAC_W);
  end
endmodule

// File: rtl/nnag_round.sv
`timescale 1ns/1ps
// Round half up (floor(q+0.5)) and range-check against [0, LIMIT).
module nnag_round #(
  parameter int SUM_W  = 32,
  parameter int FRAC_W = 9,
  parameter int LIMIT  = 480,
  localparam int RND_W = SUM_W - FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SUM_W-1:0] q_i,
  output logic signed [RND_W-1:0] rnd_o,
  output logic                    oor_o
);
  localparam logic signed [SUM_W-1:0] HALF  = SUM_W'(2 ** (FRAC_W - 1));
  localparam logic signed [RND_W-1:0] LIM_S = RND_W'(LIMIT);

  logic signed [SUM_W-1:0] biased;
  logic signed [RND_W-1:0] rnd_d;
  logic                    oor_d;

  always_comb begin
    biased = q_i + HALF;
    rnd_d  = RND_W'(biased >>> FRAC_W);
    oor_d  = rnd_d[RND_W-1] | (rnd_d >= LIM_S);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_o <= '0;
      oor_o <= 1'b0;
    end else begin
      rnd_o <= rnd_d;
      oor_o <= oor_d;
    end
  end
endmodule

// File: rtl/nnag_addr.sv
`timescale 1ns/1ps
// Final stage: raster address, zeroed when either axis is off-frame.
module nnag_addr #(
  parameter int SRC_W  = 640,
  parameter int SRC_H  = 480,
  parameter int RND_W  = 23,
  parameter int ADDR_W = 19,
  localparam int ROW_W = $clog2(SRC_H),
  localparam int COL_W = $clog2(SRC_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [RND_W-1:0] row_i,
  input  logic signed [RND_W-1:0] col_i,
  input  logic                    oor_row_i,
  input  logic                    oor_col_i,
  output logic signed [RND_W-1:0] row_o,
  output logic signed [RND_W-1:0] col_o,
  output logic                    oor_o,
  output logic [ADDR_W-1:0]       addr_o
);
  logic [ROW_W-1:0]  row_lo;
  logic [COL_W-1:0]  col_lo;
  logic [ADDR_W-1:0] base;
  logic              oor_d;
  logic [ADDR_W-1:0] addr_d;

  assign row_lo = row_i[ROW_W-1:0];
  assign col_lo = col_i[COL_W-1:0];

  generate
    if (SRC_W == 640) begin : g_shift
      // 640 = 512 + 128
      assign base = (ADDR_W'(row_lo) << 9) + (ADDR_W'(row_lo) << 7);
    end else begin : g_mult
      assign base = ADDR_W'(row_lo) * ADDR_W'(SRC_W);
    end
  endgenerate

  always_comb begin
    oor_d  = oor_row_i | oor_col_i;
    addr_d = oor_d ? '0 : base + ADDR_W'(col_lo);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o  <= '0;
      col_o  <= '0;
      oor_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      row_o  <= row_i;
      col_o  <= col_i;
      oor_o  <= oor_d;
      addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/nn_src_addr_gen.sv
`timescale 1ns/1ps
module nn_src_addr_gen
  import nnag_pkg::*;
#(
  parameter int COEF_W = 18,
  parameter int EDGE_W = 12,
  parameter int VTX_W  = 12,
  parameter int FRAC_W = 9,
  parameter int SRC_W  = 640,
  parameter int SRC_H  = 480,
  localparam int SUM_W  = COEF_W + EDGE_W + 2,
  localparam int RND_W  = SUM_W - FRAC_W,
  localparam int ADDR_W = $clog2(SRC_W * SRC_H)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [COEF_W-1:0] y0_i,
  input  logic signed [COEF_W-1:0] y1_i,
  input  logic signed [VTX_W-1:0]  vr_i,
  input  logic signed [VTX_W-1:0]  vc_i,
  input  logic signed [EDGE_W-1:0] er0_i,
  input  logic signed [EDGE_W-1:0] er1_i,
  input  logic signed [EDGE_W-1:0] ec0_i,
  input  logic signed [EDGE_W-1:0] ec1_i,
  output logic                     valid_o,
  output logic signed [RND_W-1:0]  row_o,
  output logic signed [RND_W-1:0]  col_o,
  output logic                     oor_o,
  output logic [ADDR_W-1:0]        addr_o
);
  localparam int PIPE_D = 4;

  logic signed [EDGE_W-1:0] e0_a  [NUM_AX];
  logic signed [EDGE_W-1:0] e1_a  [NUM_AX];
  logic signed [VTX_W-1:0]  vtx_a [NUM_AX];
  logic signed [SUM_W-1:0]  q_a   [NUM_AX];
  logic signed [RND_W-1:0]  rnd_a [NUM_AX];
  logic                     oor_a [NUM_AX];
  logic [PIPE_D-1:0]        vld_q;

  assign e0_a[AX_ROW]  = er0_i;
  assign e1_a[AX_ROW]  = er1_i;
  assign vtx_a[AX_ROW] = vr_i;
  assign e0_a[AX_COL]  = ec0_i;
  assign e1_a[AX_COL]  = ec1_i;
  assign vtx_a[AX_COL] = vc_i;

  generate
    for (genvar g = 0; g < NUM_AX; g++) begin : g_axis
      nnag_axis_mac #(
        .COEF_W(COEF_W), .EDGE_W(EDGE_W), .VTX_W(VTX_W), .FRAC_W(FRAC_W)
      ) mac_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .y0_i  (y0_i),
        .y1_i  (y1_i),
        .e0_i  (e0_a[g]),
        .e1_i  (e1_a[g]),
        .vtx_i (vtx_a[g]),
        .q_o   (q_a[g])
      );

      nnag_round #(
        .SUM_W (SUM_W),
        .FRAC_W(FRAC_W),
        .LIMIT (axis_limit(axis_e'(g), SRC_H, SRC_W))
      ) rnd_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .q_i   (q_a[g]),
        .rnd_o (rnd_a[g]),
        .oor_o (oor_a[g])
      );
    end
  endgenerate

  nnag_addr #(
    .SRC_W(SRC_W), .SRC_H(SRC_H), .RND_W(RND_W), .ADDR_W(ADDR_W)
  ) addr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .row_i    (rnd_a[AX_ROW]),
    .col_i    (rnd_a[AX_COL]),
    .oor_row_i(oor_a[AX_ROW]),
    .oor_col_i(oor_a[AX_COL]),
    .row_o    (row_o),
    .col_o    (col_o),
    .oor_o    (oor_o),
    .addr_o   (addr_o)
  );

  // Valid rides alongside the data, no stall path.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[PIPE_D-2:0], valid_i};
  end

  assign valid_o = vld_q[PIPE_D-1];
endmodule

// File: rtl/nnag_chk.sv
`timescale 1ns/1ps
module nnag_chk #(
  parameter int SRC_W  = 640,
  parameter int SRC_H  = 480,
  parameter int RND_W  = 23,
  parameter int ADDR_W = 19
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic signed [RND_W-1:0] row_o,
  input logic signed [RND_W-1:0] col_o,
  input logic                    oor_o,
  input logic [ADDR_W-1:0]       addr_o
);
  localparam logic signed [RND_W-1:0] H_S = RND_W'(SRC_H);
  localparam logic signed [RND_W-1:0] W_S = RND_W'(SRC_W);

  logic [2:0] cyc_q;
  logic       row_in, col_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 3'd4)   cyc_q <= cyc_q + 3'd1;
  end

  assign row_in = !row_o[RND_W-1] && (row_o < H_S);
  assign col_in = !col_o[RND_W-1] && (col_o < W_S);

  a_r4_no_early_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 3'd4) |-> !valid_o);

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 3'd4) |-> (valid_o == $past(valid_i, 4)));

  a_r6_oor_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && oor_o) |-> (addr_o == '0));

  a_r6_oor_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && oor_o) |-> !(row_in && col_in));

  a_r6_inrange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !oor_o) |-> (row_in && col_in));

  a_r3_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !oor_o) |-> (int'(addr_o) < SRC_W * SRC_H));

  a_r3_addr_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !oor_o) |->
      (addr_o == ADDR_W'(row_o) * ADDR_W'(SRC_W) + ADDR_W'(col_o)));
endmodule

bind nn_src_addr_gen nnag_chk #(
  .SRC_W(SRC_W), .SRC_H(SRC_H), .RND_W(RND_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .valid_o(valid_o),
  .row_o  (row_o),
  .col_o  (col_o),
  .oor_o  (oor_o),
  .addr_o (addr_o)
);

// File: tb/nn_src_addr_gen_tb_top.sv
`timescale 1ns/1ps
module nn_src_addr_gen_tb_top;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic signed [17:0] y0_i = '0, y1_i = '0;
  logic signed [11:0] vr_i = '0, vc_i = '0;
  logic signed [11:0] er0_i = '0, er1_i = '0, ec0_i = '0, ec1_i = '0;
  logic               valid_o;
  logic signed [22:0] row_o, col_o;
  logic               oor_o;
  logic [18:0]        addr_o;

  typedef struct packed {
    int     due;
    longint row;
    longint col;
    bit     oor;
    int     addr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    g_vr, g_vc, g_er0, g_er1, g_ec0, g_ec1;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  nn_src_addr_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .y0_i(y0_i), .y1_i(y1_i), .vr_i(vr_i), .vc_i(vc_i),
    .er0_i(er0_i), .er1_i(er1_i), .ec0_i(ec0_i), .ec1_i(ec1_i),
    .valid_o(valid_o), .row_o(row_o), .col_o(col_o),
    .oor_o(oor_o), .addr_o(addr_o)
  );

  // floor(q + 0.5) with q in 9-bit fixed point
  function automatic longint round_axis(longint y0, longint y1, longint e0,
                                        longint e1, longint v);
    longint q;
    q = y0 * e0 + y1 * e1 + v * 512;
    return (q + 256) >>> 9;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compare each output against its due cycle and value.
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (exp_q.size() > 0 && exp_q[0].due < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s missing valid_o: actual=0 expected=1 (due cycle %0d)",
                 tag_q[0], exp_q[0].due);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4 unexpected valid_o: actual=1 expected=0 at cycle %0d", cyc);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_chk++;
          if (e.due != cyc || longint'(row_o) != e.row || longint'(col_o) != e.col ||
              oor_o != e.oor || int'(addr_o) != e.addr) begin
            n_fail++;
            $display("FAIL %s: actual cyc=%0d row=%0d col=%0d oor=%0d addr=%0d expected cyc=%0d row=%0d col=%0d oor=%0d addr=%0d",
                     t, cyc, row_o, col_o, oor_o, addr_o,
                     e.due, e.row, e.col, e.oor, e.addr);
          end
        end
      end
    end
  end

  task automatic set_geom(int vr, int vc, int er0, int er1, int ec0, int ec1);
    g_vr = vr; g_vc = vc; g_er0 = er0; g_er1 = er1; g_ec0 = ec0; g_ec1 = ec1;
    vr_i  = 12'(vr);  vc_i  = 12'(vc);
    er0_i = 12'(er0); er1_i = 12'(er1);
    ec0_i = 12'(ec0); ec1_i = 12'(ec1);
  endtask

  // Called right after a falling edge; leaves on the next one.
  task automatic push_pix(int y0, int y1, string tag);
    exp_t e;
    e.row  = round_axis(y0, y1, g_er0, g_er1, g_vr);
    e.col  = round_axis(y0, y1, g_ec0, g_ec1, g_vc);
    e.oor  = (e.row < 0 || e.row > 479 || e.col < 0 || e.col > 639);
    e.addr = e.oor ? 0 : int'(e.row * 640 + e.col);
    e.due  = cyc + 4;
    y0_i    = 18'(y0);
    y1_i    = 18'(y1);
    valid_i = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (7) @(negedge clk_i);
    chk(tag, "pending results after drain", exp_q.size(), 0);
  endtask

  // R8: reset values
  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R8", "valid_o in reset", valid_o, 0);
    chk("R8", "oor_o in reset", oor_o, 0);
    chk("R8", "addr_o in reset", addr_o, 0);
    chk("R8", "row_o in reset", row_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R4", "valid_o idle after reset", valid_o, 0);
  endtask

  // R1 R3: general geometry, isolated pixels (also R4 through the due cycle)
  task automatic t_mapping;
    set_geom(10, 20, 400, 30, -20, 500);
    @(negedge clk_i);
    push_pix(256, 128, "R1");
    repeat (2) @(negedge clk_i);
    push_pix(0, 0, "R3");
    repeat (5) @(negedge clk_i);
    push_pix(512, 512, "R1");
    push_pix(100, 900, "R3");
    drain("R1");
    set_geom(0, 0, 480, 0, 0, 640);
    @(negedge clk_i);
    push_pix(384, 64, "R3");
    drain("R3");
  endtask

  // R2: exact half and just-below-half on both axes
  task automatic t_round;
    set_geom(5, 7, 1, 0, 0, 1);
    @(negedge clk_i);
    push_pix(256, 255, "R2");   // 5.5 -> 6, 7.498 -> 7
    push_pix(255, 256, "R2");   // 5.498 -> 5, 7.5 -> 8
    push_pix(511, 1, "R2");
    drain("R2");
  endtask

  // R7: negative coefficients, anchors and edges
  task automatic t_negative;
    set_geom(100, 50, 1, 0, 0, 1);
    @(negedge clk_i);
    push_pix(-1792, -1793, "R7"); // 96.5 -> 97, 46.498 -> 46
    set_geom(200, 300, -100, 0, 0, -50);
    @(negedge clk_i);
    push_pix(-300, 700, "R7");
    drain("R7");
  endtask

  // R6: frame edges where rounding decides the range check
  task automatic t_range;
    set_geom(479, 639, 1, 0, 0, 1);
    @(negedge clk_i);
    push_pix(255, 255, "R6");   // 479, 639 in range, addr 307199
    push_pix(256, 0, "R6");     // row 480 out
    push_pix(0, 256, "R6");     // col 640 out
    set_geom(0, 0, 1, 0, 0, 1);
    @(negedge clk_i);
    push_pix(-256, -256, "R6"); // -0.5 -> 0, in range
    push_pix(-257, 0, "R6");    // row -1 out
    push_pix(0, -257, "R6");    // col -1 out
    drain("R6");
  endtask

  // R5: burst on consecutive cycles
  task automatic t_burst;
    set_geom(3, 9, 470, 5, -8, 630);
    @(negedge clk_i);
    for (int i = 0; i < 10; i++) push_pix(i * 55, 512 - i * 50, "R5");
    drain("R5");
  endtask

  initial begin
    t_reset();
    t_mapping();
    t_round();
    t_negative();
    t_range();
    t_burst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog: actual=hung expected=complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule